// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Frame Receiver

This block takes a serial line and rebuilds ten-bit asynchronous characters from it. Each character has a low start bit, eight data bits with the least significant first, and a high stop bit. A one-cycle sample enable arrives sixteen times per bit period. While the receiver waits for a character, it watches the synchronized line on every sample enable for a high-to-low step. When it sees one, it restarts its slice counter, so that every later bit is split into sixteen slices that follow the real edge. Three mid-bit samples are taken for each bit, and the bit is the majority of the three.

The start bit is checked first. If it votes high, the edge was noise and the receiver drops back to waiting. A good start is followed by eight data bits and then the stop bit. At the middle of the stop bit the receiver decides whether to deliver the character. It delivers only when the previous character has already been taken, shown by the full flag being low. In addressed-multidrop mode it also needs the stop bit to be high. When it delivers, it loads the byte, records the stop bit and raises the full flag. The flag stays up until a one-cycle clear strobe, and a delivery in the same cycle as the strobe takes priority. Dropping the enable input abandons any character in progress.

Top module: `uart_os_rx`

## Requirements
- R1: A falling edge that arrives while `rx_en` is low starts no character. A whole frame sent with `rx_en` low leaves `rx_byte`, `rx_stop` and `rx_full` unchanged.
- R2: `rxd` passes through a two-flop synchronizer. A high-to-low step seen on an `os_tick` while idle marks that tick as slice 0 of the start bit. Each later tick advances the slice number, which wraps from 15 to 0.
- R3: Each bit is the majority of the line levels seen on the ticks of slices 7, 8 and 9 (numbered from 0). One disagreeing sample among the three is outvoted. Levels on other slices (for example 6 and 10) have no effect. Two disagreeing samples decide the bit.
- R4: If the start bit votes 1, the receiver abandons the character with no register change and goes back to watching for a falling edge. A following good frame is received normally.
- R5: The eight data bits follow the start bit least significant first. The first data bit received ends up in `rx_byte[0]`.
- R6: At the stop-bit vote, the character is delivered only when `rx_full` is 0 and either `mp_mode` is 0 or the stop bit votes 1. Otherwise `rx_byte`, `rx_stop` and `rx_full` keep their values.
- R7: On delivery, `rx_byte` takes the eight data bits, `rx_stop` takes the voted stop bit, and `rx_full` becomes 1, all on the same tick edge.
- R8: Right after the stop-bit vote (slice 9) the receiver is idle again. A start edge on slice 10 of the stop bit begins the next character.
- R9: `rx_full` stays 1 until `flag_clr` is high for a cycle, after which it reads 0. `rx_byte` is not changed by the clear.
- R10: If a delivery and `flag_clr` fall in the same cycle, `rx_full` ends up 1.
- R11: Taking `rx_en` low in the middle of a character abandons that character, with no change to `rx_byte`, `rx_stop` or `rx_full`.
- R12: After reset, `rx_byte` is 0x00, `rx_stop` is 0 and `rx_full` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | One-cycle sample enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idles high |
| rx_en | input | 1 | Receive enable; low blocks new characters and abandons one in progress |
| mp_mode | input | 1 | Multidrop mode; requires a high stop bit for delivery |
| flag_clr | input | 1 | One-cycle strobe that clears `rx_full` |
| rx_byte | output | 8 | Last delivered data byte |
| rx_stop | output | 1 | Stop-bit level of the last delivered character |
| rx_full | output | 1 | Character-delivered flag |

## Verification
The hardest cases to reach from the ports depend on which slice a line change falls on. Examples are a single bad sample inside the three-sample window, a start edge on slice 10 of a stop bit, and a clear strobe in the exact cycle of delivery. The bench produces the sample enable itself at a fixed phase. It changes `rxd` only just after an enable, one slice at a time. Because the synchronizer delay is shorter than the enable spacing, every driven slice lines up with a known slice number. That makes single-slice glitches, back-to-back frames and a strobe timed to the delivery edge repeatable.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

    localparam int unsigned OS_RATE    = 16;
    localparam int unsigned CHAR_BITS  = 8;
    localparam int unsigned MID_FIRST  = 7;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } rx_phase_e;

    typedef struct packed {
        logic valid;
        logic level;
    } vote_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxo_line_sync.sv
module rxo_line_sync #(
    parameter int unsigned DEPTH = uart_os_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd_async,
    output logic line_q,
    output logic fall_seen
);
    logic [DEPTH-1:0] chain_q;
    logic             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], rxd_async};
        end
    end

    assign line_q = chain_q[DEPTH-1];

    // level seen on the previous sample enable
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else if (tick) begin
            prev_q <= line_q;
        end
    end

    assign fall_seen = tick & prev_q & ~line_q;

endmodule

// File: rtl/rxo_slice_vote.sv
module rxo_slice_vote
    import uart_os_pkg::*;
#(
    parameter int unsigned OSR   = OS_RATE,
    parameter int unsigned FIRST = MID_FIRST
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  realign,
    input  logic  line_q,
    output vote_t vote
);
    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned LAST = FIRST + 2;
    localparam logic [CW-1:0] TOP_C   = CW'(OSR - 1);
    localparam logic [CW-1:0] FIRST_C = CW'(FIRST);
    localparam logic [CW-1:0] LAST_C  = CW'(LAST);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    // slice number that the next sample enable belongs to
    logic [CW-1:0] slice_q;
    logic [1:0]    early_q;
    logic          in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            slice_q <= '0;
        end else if (tick) begin
            if (realign) begin
                slice_q <= ONE_C;
            end else if (slice_q == TOP_C) begin
                slice_q <= '0;
            end else begin
                slice_q <= slice_q + ONE_C;
            end
        end
    end

    assign in_window = (slice_q >= FIRST_C) && (slice_q < LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= '0;
        end else if (tick && !realign && in_window) begin
            early_q <= {early_q[0], line_q};
        end
    end

    always_comb begin
        vote.valid = tick && !realign && (slice_q == LAST_C);
        vote.level = vote3(early_q[1], early_q[0], line_q);
    end

    AST_REALIGN_SLICE: assert property (@(posedge clk) disable iff (rst)
        (tick && realign) |=> (slice_q == ONE_C)); // R2

    AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> $stable(slice_q)); // R2

endmodule

// File: rtl/rxo_frame_ctrl.sv
module rxo_frame_ctrl
    import uart_os_pkg::*;
#(
    parameter int unsigned DW = CHAR_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          fall_seen,
    input  vote_t         vote,
    output logic          realign,
    output logic          fire,
    output logic          stop_level,
    output logic [DW-1:0] frame_bits
);
    localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

    rx_phase_e     phase_q, phase_d;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] shreg_q;

    assign realign = (phase_q == PH_IDLE) && rx_en && fall_seen;

    always_comb begin
        phase_d = phase_q;
        if (phase_q != PH_IDLE && !rx_en) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  if (realign) phase_d = PH_START;
                PH_START: if (vote.valid) phase_d = vote.level ? PH_IDLE : PH_DATA;
                PH_DATA:  if (vote.valid && idx_q == IDX_LAST) phase_d = PH_STOP;
                PH_STOP:  if (vote.valid) phase_d = PH_IDLE;
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_START) begin
                idx_q <= '0;
            end else if (phase_q == PH_DATA && rx_en && vote.valid) begin
                shreg_q <= {vote.level, shreg_q[DW-1:1]};
                idx_q   <= idx_q + IW'(1);
            end
        end
    end

    assign fire       = (phase_q == PH_STOP) && rx_en && vote.valid;
    assign stop_level = vote.level;
    assign frame_bits = shreg_q;

    AST_IDLE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !rx_en) |=> (phase_q == PH_IDLE)); // R1

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_START && rx_en && vote.valid && vote.level) |=> (phase_q == PH_IDLE)); // R4

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STOP && vote.valid) |=> (phase_q == PH_IDLE)); // R8

    AST_EN_ABORT: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && !rx_en) |=> (phase_q == PH_IDLE)); // R11

endmodule

// File: rtl/rxo_commit.sv
module rxo_commit
    import uart_os_pkg::*;
#(
    parameter int unsigned DW = CHAR_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          stop_level,
    input  logic [DW-1:0] frame_bits,
    input  logic          mp_mode,
    input  logic          flag_clr,
    output logic [DW-1:0] byte_q,
    output logic          stop_q,
    output logic          full_q
);
    logic accept;

    assign accept = fire && !full_q && (!mp_mode || stop_level);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            stop_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (accept) begin
                byte_q <= frame_bits;
                stop_q <= stop_level;
            end
            if (accept) begin
                full_q <= 1'b1;
            end else if (flag_clr) begin
                full_q <= 1'b0;
            end
        end
    end

    AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        full_q |=> ($stable(byte_q) && $stable(stop_q))); // R6

    AST_MP_LOW_STOP: assert property (@(posedge clk) disable iff (rst)
        (fire && mp_mode && !stop_level) |=> ($stable(byte_q) && $stable(stop_q))); // R6

    AST_LOAD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (fire && !full_q && !mp_mode) |=> (byte_q == $past(frame_bits))); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (fire && !full_q && (!mp_mode || stop_level)) |=> full_q); // R10

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !fire) |=> !full_q); // R9

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_pkg::*;
#(
    parameter int unsigned OSR        = OS_RATE,
    parameter int unsigned DW         = CHAR_BITS,
    parameter int unsigned FIRST      = MID_FIRST,
    parameter int unsigned SYNC_STAGE = SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          rx_en,
    input  logic          mp_mode,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_byte,
    output logic          rx_stop,
    output logic          rx_full
);
    logic          line_q;
    logic          fall_seen;
    logic          realign;
    logic          fire;
    logic          stop_level;
    logic [DW-1:0] frame_bits;
    vote_t         vote;

    rxo_line_sync #(.DEPTH(SYNC_STAGE)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tick      (os_tick),
        .rxd_async (rxd),
        .line_q    (line_q),
        .fall_seen (fall_seen)
    );

    rxo_slice_vote #(.OSR(OSR), .FIRST(FIRST)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .realign (realign),
        .line_q  (line_q),
        .vote    (vote)
    );

    rxo_frame_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .fall_seen  (fall_seen),
        .vote       (vote),
        .realign    (realign),
        .fire       (fire),
        .stop_level (stop_level),
        .frame_bits (frame_bits)
    );

    rxo_commit #(.DW(DW)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .stop_level (stop_level),
        .frame_bits (frame_bits),
        .mp_mode    (mp_mode),
        .flag_clr   (flag_clr),
        .byte_q     (rx_byte),
        .stop_q     (rx_stop),
        .full_q     (rx_full)
    );

endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       os_tick;
    logic       rxd;
    logic       rx_en;
    logic       mp_mode;
    logic       flag_clr;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_full;

    int checks = 0;
    int errors = 0;
    logic [15:0] gmask [10];

    always #5 clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk      (clk),
        .rst      (rst),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .rx_en    (rx_en),
        .mp_mode  (mp_mode),
        .flag_clr (flag_clr),
        .rx_byte  (rx_byte),
        .rx_stop  (rx_stop),
        .rx_full  (rx_full)
    );

    // sample enable: one cycle in four
    initial begin
        os_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    task automatic check(input string req, input logic [7:0] eb, input logic es, input logic ef);
        checks++;
        if (rx_byte !== eb || rx_stop !== es || rx_full !== ef) begin
            errors++;
            $display("FAIL %s: byte=%h stop=%b full=%b expected byte=%h stop=%b full=%b",
                     req, rx_byte, rx_stop, rx_full, eb, es, ef);
        end
    endtask

    // returns at the falling edge just after a sample-enable cycle
    task automatic wait_tick;
        do @(posedge clk); while (os_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            wait_tick();
            rxd      = 1'b1;
            flag_clr = 1'b0;
        end
    endtask

    task automatic clear_flag;
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    // slot s of a bit is seen by the receiver as slice s
    task automatic send_frame(input logic [7:0] d, input logic sb, input int lead,
                              input int stop_slots, input int tail,
                              input bit clr_commit, input bit clr_start,
                              input int en_off_bit);
        logic [9:0] bits;
        bits = {sb, d, 1'b0};
        idle_ticks(lead);
        for (int b = 0; b < 10; b++) begin
            for (int s = 0; s < ((b == 9) ? stop_slots : 16); s++) begin
                wait_tick();
                rxd      = bits[b] ^ gmask[b][s];
                flag_clr = (clr_commit && b == 9 && s == 9) || (clr_start && b == 0 && s == 0);
                if (b == en_off_bit && s == 0) rx_en = 1'b0;
                if (b == en_off_bit && s == 2) rx_en = 1'b1;
            end
        end
        idle_ticks(tail);
        for (int b = 0; b < 10; b++) gmask[b] = '0;
    endtask

    task automatic t_reset;
        check("R12 reset values", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_basic;
        send_frame(8'hA5, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R5 R7 basic delivery", 8'hA5, 1'b1, 1'b1);
        repeat (200) @(negedge clk);
        check("R9 flag held", 8'hA5, 1'b1, 1'b1);
    endtask

    task automatic t_hold_full;
        send_frame(8'h3C, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R6 blocked while full", 8'hA5, 1'b1, 1'b1);
        clear_flag();
        check("R9 clear strobe", 8'hA5, 1'b1, 1'b0);
    endtask

    task automatic t_multidrop;
        mp_mode = 1'b1;
        send_frame(8'h77, 1'b0, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R6 multidrop low stop dropped", 8'hA5, 1'b1, 1'b0);
        send_frame(8'h81, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R7 multidrop high stop delivered", 8'h81, 1'b1, 1'b1);
        clear_flag();
        mp_mode = 1'b0;
        send_frame(8'h42, 1'b0, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R6 R7 normal mode low stop delivered", 8'h42, 1'b0, 1'b1);
        clear_flag();
    endtask

    task automatic t_vote;
        gmask[0] = 16'h0100;   // start: slice 8 high, outvoted
        gmask[1] = 16'h0080;   // bit0 slice 7
        gmask[2] = 16'h0100;   // bit1 slice 8
        gmask[3] = 16'h0200;   // bit2 slice 9
        gmask[4] = 16'h0440;   // bit3 slices 6 and 10, outside window
        gmask[5] = 16'h0180;   // bit4 slices 7,8 flip the bit
        gmask[6] = 16'h0300;   // bit5 slices 8,9 flip the bit
        send_frame(8'h3C, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R3 majority vote", 8'h0C, 1'b1, 1'b1);
        clear_flag();
    endtask

    task automatic t_false_start;
        wait_tick();
        for (int s = 0; s < 6; s++) begin
            rxd = 1'b0;
            wait_tick();
        end
        idle_ticks(40);
        check("R4 false start ignored", 8'h0C, 1'b1, 1'b0);
        send_frame(8'h99, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R4 receive after false start", 8'h99, 1'b1, 1'b1);
        clear_flag();
    endtask

    task automatic t_enable;
        rx_en = 1'b0;
        send_frame(8'h11, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R1 disabled frame ignored", 8'h99, 1'b1, 1'b0);
        rx_en = 1'b1;
        send_frame(8'h00, 1'b0, 2, 16, 3, 1'b0, 1'b0, 4);
        check("R11 mid-frame disable aborts", 8'h99, 1'b1, 1'b0);
        send_frame(8'hE7, 1'b1, 2, 16, 3, 1'b0, 1'b0, -1);
        check("R11 receive after abort", 8'hE7, 1'b1, 1'b1);
        clear_flag();
    endtask

    task automatic t_set_wins;
        send_frame(8'h6B, 1'b1, 2, 16, 3, 1'b1, 1'b0, -1);
        check("R10 set wins over clear", 8'h6B, 1'b1, 1'b1);
        clear_flag();
        check("R9 clear after set", 8'h6B, 1'b1, 1'b0);
    endtask

    task automatic t_back_to_back;
        send_frame(8'h1E, 1'b1, 2, 10, 0, 1'b0, 1'b0, -1);
        send_frame(8'hD2, 1'b1, 0, 16, 3, 1'b0, 1'b1, -1);
        check("R8 start on stop slice 10", 8'hD2, 1'b1, 1'b1);
        clear_flag();
    endtask

    initial begin
        rst      = 1'b1;
        rxd      = 1'b1;
        rx_en    = 1'b1;
        mp_mode  = 1'b0;
        flag_clr = 1'b0;
        for (int b = 0; b < 10; b++) gmask[b] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold_full();
        t_multidrop();
        t_vote();
        t_false_start();
        t_enable();
        t_set_wins();
        t_back_to_back();
        report();
    end

endmodule